// File: doc/BRIEF.md
# ADC Conversion Sequence Controller

This block decides which analog channel a converter samples next and when it does so. It holds two ordered channel lists. The regular list has 1 to 16 entries and the injected list has 1 to 4. Each entry is a 5-bit channel number. Software start pulses or edge-qualified external trigger inputs launch a list. The controller then walks through it in single, continuous or discontinuous fashion. The injected list always takes priority at channel boundaries.

The converter is modelled inside the block as a busy window. Its length is the channel's own sample time plus a resolution-dependent conversion time. For the whole window the block presents the channel number and the group it belongs to. When a channel finishes, the block emits one-cycle event pulses and sets sticky flags. The flags hold until they are cleared. List contents, lengths and modes come from configuration inputs. A separate strobe tells the controller that a list was rewritten.

Top module: `adcseq_ctrl`

## Requirements
- R1: Regular list length is `reg_len_m1`+1 (1..16) and injected list length is `inj_len_m1`+1 (1..4). Entry k of a list sits at bits [5k+4:5k] of its flat vector. Entries are converted in increasing k.
- R2: With `reg_disc_en`=1, each regular start converts the next `reg_burst_m1`+1 (1..8) consecutive entries. A burst ends early when it reaches the last entry.
- R3: In regular discontinuous mode, the start that follows a burst which reached the last entry begins again at entry 0.
- R4: With `inj_disc_en`=1, each injected start converts exactly one injected entry. After the last entry, the next one converted is entry 0.
- R5: With `auto_inj_en`=1, the whole injected list runs directly after the last regular entry completes, and `inj_trig` edges are ignored.
- R6: With `cont_en`=1 and discontinuous mode off, a new regular pass starts as soon as the previous one ends. With `cont_en`=0, the controller stops after one pass.
- R7: A start request shows on `reg_start_pend`/`inj_start_pend`. It drops in the same cycle that `conv_busy` rises for the conversion it launched.
- R8: The edge select codes are 2'b00 off, 2'b01 rising, 2'b10 falling and 2'b11 both.
- R9: `conv_busy` stays high for (sample code + 1) + (resolution bits + 3) cycles. The sample code is the 3-bit field of the channel at `smp_time[3c+2:3c]`. `res_sel` selects 12/10/8/6 bits for 0/1/2/3. `eoc_pulse` rises in the first cycle after `conv_busy` falls.
- R10: A pulse on `seq_wr` ends any conversion in the next cycle without an end-of-conversion event. Each pass that was in progress restarts at entry 0.
- R11: An injected start that arrives during a regular pass is served once the current channel finishes. The regular pass then resumes at its next entry.
- R12: `eoc_pulse` fires for every channel. `eos_pulse` fires with the last regular entry and `jeos_pulse` with the last injected entry. `eoc_flag`, `eos_flag` and `jeos_flag` are sticky and are cleared by `flag_clr` bits 0, 1 and 2. A set in the same cycle wins over a clear. After reset all flags and pending bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_seq | input | 80 | Regular channel list, entry k at [5k+4:5k] |
| reg_len_m1 | input | 4 | Regular list length minus one |
| inj_seq | input | 20 | Injected channel list, entry k at [5k+4:5k] |
| inj_len_m1 | input | 2 | Injected list length minus one |
| smp_time | input | 96 | Per-channel 3-bit sample code, channel c at [3c+2:3c] |
| res_sel | input | 2 | Resolution select: 0=12, 1=10, 2=8, 3=6 bits |
| cont_en | input | 1 | Continuous regular passes |
| reg_disc_en | input | 1 | Regular burst mode |
| reg_burst_m1 | input | 3 | Burst length minus one |
| inj_disc_en | input | 1 | One injected entry per start |
| auto_inj_en | input | 1 | Chain injected list after regular list |
| reg_edge_sel | input | 2 | Regular trigger edge select |
| inj_edge_sel | input | 2 | Injected trigger edge select |
| reg_trig | input | 1 | Regular external trigger |
| inj_trig | input | 1 | Injected external trigger |
| reg_sw_start | input | 1 | Regular software start pulse |
| inj_sw_start | input | 1 | Injected software start pulse |
| seq_wr | input | 1 | List-rewritten strobe: abort and restart |
| flag_clr | input | 3 | Flag clear: bit0 eoc, bit1 eos, bit2 jeos |
| reg_start_pend | output | 1 | Regular start pending |
| inj_start_pend | output | 1 | Injected start pending |
| conv_busy | output | 1 | Conversion window active |
| conv_ch | output | 5 | Channel being (or last) converted |
| conv_is_inj | output | 1 | Current channel belongs to injected list |
| eoc_pulse | output | 1 | Channel complete |
| eos_pulse | output | 1 | Regular list complete |
| jeos_pulse | output | 1 | Injected list complete |
| eoc_flag | output | 1 | Sticky channel-complete flag |
| eos_flag | output | 1 | Sticky regular-complete flag |
| jeos_flag | output | 1 | Sticky injected-complete flag |

## Verification
Several properties are checked on every cycle. Every end-of-conversion pulse must follow a busy window of exactly the length computed from that channel's sample code and the resolution. The channel number must hold steady while busy. Group-complete pulses must coincide with a channel pulse of the matching group, the rewrite strobe must always empty the converter, and the flags must stay set until cleared. The ordering behaviour can only be shown by the bench's scenarios, because it spans many conversions and depends on history: burst boundaries and wrap-around, injected preemption and resumption, chaining in automatic mode, continuous restarts, edge selection and restart after a rewrite.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  // Resolution select to number of result bits: 0->12, 1->10, 2->8, 3->6
  function automatic int unsigned res_bits(int unsigned rsel);
    return 12 - 2 * (rsel & 3);
  endfunction

  // Total conversion window: sampling (code+1) plus resolution + 3
  function automatic int unsigned conv_len(int unsigned smp_code, int unsigned rsel);
    return (smp_code + 1) + res_bits(rsel) + 3;
  endfunction

  // Edge qualification: bit0 enables rising, bit1 enables falling
  function automatic logic edge_hit(logic [1:0] sel, logic prev, logic cur);
    return (sel[0] & cur & ~prev) | (sel[1] & ~cur & prev);
  endfunction

endpackage

// File: rtl/adcseq_trig.sv
module adcseq_trig (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] edge_sel,
  input  logic       ext_in,
  input  logic       mask,
  input  logic       sw_set,
  input  logic       restart,
  input  logic       take,
  output logic       pend
);
  logic prev_q;
  logic hit;

  assign hit = !mask && adcseq_pkg::edge_hit(edge_sel, prev_q, ext_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      prev_q <= ext_in;
      pend   <= (pend && !take) || sw_set || hit || restart;
    end
  end
endmodule

// File: rtl/adcseq_timer.sv
module adcseq_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [CNT_W-1:0] load,
  output logic             busy,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  assign done = busy && (cnt_q == '0) && !abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (abort) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= load;
    end else if (done) begin
      busy  <= 1'b0;
    end else if (busy) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/adcseq_flags.sv
module adcseq_flags #(
  parameter int NFLAG = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set,
  input  logic [NFLAG-1:0] clr,
  output logic [NFLAG-1:0] flag
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag[i] <= 1'b0;
      else        flag[i] <= (flag[i] && !clr[i]) || set[i];
    end
  end
endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl #(
  parameter int CH_W      = 5,
  parameter int REG_MAX   = 16,
  parameter int INJ_MAX   = 4,
  parameter int SMP_W     = 3,
  parameter int MAX_BURST = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [REG_MAX*CH_W-1:0]           reg_seq,
  input  logic [$clog2(REG_MAX)-1:0]        reg_len_m1,
  input  logic [INJ_MAX*CH_W-1:0]           inj_seq,
  input  logic [$clog2(INJ_MAX)-1:0]        inj_len_m1,
  input  logic [(1<<CH_W)*SMP_W-1:0]        smp_time,
  input  logic [1:0]                        res_sel,
  input  logic                              cont_en,
  input  logic                              reg_disc_en,
  input  logic [$clog2(MAX_BURST)-1:0]      reg_burst_m1,
  input  logic                              inj_disc_en,
  input  logic                              auto_inj_en,
  input  logic [1:0]                        reg_edge_sel,
  input  logic [1:0]                        inj_edge_sel,
  input  logic                              reg_trig,
  input  logic                              inj_trig,
  input  logic                              reg_sw_start,
  input  logic                              inj_sw_start,
  input  logic                              seq_wr,
  input  logic [2:0]                        flag_clr,
  output logic                              reg_start_pend,
  output logic                              inj_start_pend,
  output logic                              conv_busy,
  output logic [CH_W-1:0]                   conv_ch,
  output logic                              conv_is_inj,
  output logic                              eoc_pulse,
  output logic                              eos_pulse,
  output logic                              jeos_pulse,
  output logic                              eoc_flag,
  output logic                              eos_flag,
  output logic                              jeos_flag
);
  localparam int REG_IW = $clog2(REG_MAX);
  localparam int INJ_IW = $clog2(INJ_MAX);
  localparam int BL_W   = $clog2(MAX_BURST) + 1;
  localparam int CNT_W  = $clog2((1 << SMP_W) + 16);
  localparam logic [BL_W-1:0] BL_ONE = BL_W'(1);

  // Sequencing state
  logic [REG_IW-1:0] reg_pos;
  logic [INJ_IW-1:0] inj_pos;
  logic [BL_W-1:0]   burst_left;
  logic              reg_active, inj_active;

  // Named internal events
  logic idle, pick_inj_cont, pick_inj_new, pick_reg_cont, pick_reg_new;
  logic start_inj, start_reg, start_any;
  logic conv_done, reg_last, inj_last;
  logic ev_eos, ev_jeos;
  logic reg_restart, inj_restart;
  logic [CH_W-1:0]  sel_ch;
  logic [SMP_W-1:0] sel_smp;
  logic [CNT_W-1:0] load_val;

  // Start arbitration: injected work first, then regular
  assign idle          = !conv_busy && !seq_wr;
  assign pick_inj_cont = idle && inj_active;
  assign pick_inj_new  = idle && !inj_active && inj_start_pend;
  assign pick_reg_cont = idle && !inj_active && !inj_start_pend && reg_active;
  assign pick_reg_new  = idle && !inj_active && !inj_start_pend && !reg_active && reg_start_pend;
  assign start_inj     = pick_inj_cont || pick_inj_new;
  assign start_reg     = pick_reg_cont || pick_reg_new;
  assign start_any     = start_inj || start_reg;

  assign sel_ch   = start_inj ? inj_seq[inj_pos*CH_W +: CH_W] : reg_seq[reg_pos*CH_W +: CH_W];
  assign sel_smp  = smp_time[sel_ch*SMP_W +: SMP_W];
  assign load_val = CNT_W'(adcseq_pkg::conv_len(int'(sel_smp), int'(res_sel)) - 1);

  assign reg_last    = (reg_pos >= reg_len_m1);
  assign inj_last    = (inj_pos >= inj_len_m1);
  assign ev_eos      = conv_done && !conv_is_inj && reg_last;
  assign ev_jeos     = conv_done && conv_is_inj && inj_last;
  assign reg_restart = seq_wr && reg_active;
  assign inj_restart = seq_wr && inj_active;

  adcseq_trig u_reg_trig (
    .clk(clk), .rst_n(rst_n), .edge_sel(reg_edge_sel), .ext_in(reg_trig),
    .mask(1'b0), .sw_set(reg_sw_start), .restart(reg_restart),
    .take(pick_reg_new), .pend(reg_start_pend)
  );

  adcseq_trig u_inj_trig (
    .clk(clk), .rst_n(rst_n), .edge_sel(inj_edge_sel), .ext_in(inj_trig),
    .mask(auto_inj_en), .sw_set(inj_sw_start), .restart(inj_restart),
    .take(pick_inj_new), .pend(inj_start_pend)
  );

  adcseq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start_any), .abort(seq_wr),
    .load(load_val), .busy(conv_busy), .done(conv_done)
  );

  adcseq_flags #(.NFLAG(3)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .set({ev_jeos, ev_eos, conv_done}),
    .clr(flag_clr),
    .flag({jeos_flag, eos_flag, eoc_flag})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_pos     <= '0;
      inj_pos     <= '0;
      burst_left  <= '0;
      reg_active  <= 1'b0;
      inj_active  <= 1'b0;
      conv_ch     <= '0;
      conv_is_inj <= 1'b0;
    end else if (seq_wr) begin
      reg_pos    <= '0;
      inj_pos    <= '0;
      reg_active <= 1'b0;
      inj_active <= 1'b0;
    end else begin
      if (start_any) begin
        conv_ch     <= sel_ch;
        conv_is_inj <= start_inj;
      end
      if (pick_inj_new) inj_active <= 1'b1;
      if (pick_reg_new) begin
        reg_active <= 1'b1;
        burst_left <= {1'b0, reg_burst_m1} + BL_ONE;
      end
      if (conv_done && conv_is_inj) begin
        inj_pos    <= inj_last ? '0 : inj_pos + 1'b1;
        inj_active <= !inj_last && !inj_disc_en;
      end
      if (conv_done && !conv_is_inj) begin
        reg_pos <= reg_last ? '0 : reg_pos + 1'b1;
        if (reg_last) begin
          reg_active <= cont_en && !reg_disc_en;
          if (auto_inj_en) inj_active <= 1'b1;
        end else begin
          reg_active <= !reg_disc_en || (burst_left != BL_ONE);
          burst_left <= burst_left - BL_ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoc_pulse  <= 1'b0;
      eos_pulse  <= 1'b0;
      jeos_pulse <= 1'b0;
    end else begin
      eoc_pulse  <= conv_done;
      eos_pulse  <= ev_eos;
      jeos_pulse <= ev_jeos;
    end
  end
endmodule

// File: rtl/adcseq_ctrl_chk.sv
module adcseq_ctrl_chk #(
  parameter int CH_W  = 5,
  parameter int SMP_W = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       conv_busy,
  input logic [CH_W-1:0]            conv_ch,
  input logic                       conv_is_inj,
  input logic                       eoc_pulse,
  input logic                       eos_pulse,
  input logic                       jeos_pulse,
  input logic                       eos_flag,
  input logic                       seq_wr,
  input logic [2:0]                 flag_clr,
  input logic [(1<<CH_W)*SMP_W-1:0] smp_time,
  input logic [1:0]                 res_sel
);
  int busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         busy_len <= 0;
    else if (conv_busy) busy_len <= busy_len + 1;
    else                busy_len <= 0;
  end

  // R9: window length matches sample code and resolution
  assert_conv_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_pulse |-> (busy_len == int'(adcseq_pkg::conv_len(
      int'(smp_time[conv_ch*SMP_W +: SMP_W]), int'(res_sel)))));

  assert_eoc_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_pulse |-> !conv_busy);

  assert_ch_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_busy && $past(conv_busy)) |-> $stable(conv_ch));

  assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    seq_wr |=> !conv_busy);

  assert_eos_regular_R12: assert property (@(posedge clk) disable iff (!rst_n)
    eos_pulse |-> (eoc_pulse && !conv_is_inj));

  assert_jeos_injected_R12: assert property (@(posedge clk) disable iff (!rst_n)
    jeos_pulse |-> (eoc_pulse && conv_is_inj));

  assert_eos_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (eos_flag && !flag_clr[1]) |=> eos_flag);
endmodule

bind adcseq_ctrl adcseq_ctrl_chk #(.CH_W(CH_W), .SMP_W(SMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_busy(conv_busy), .conv_ch(conv_ch),
  .conv_is_inj(conv_is_inj), .eoc_pulse(eoc_pulse), .eos_pulse(eos_pulse),
  .jeos_pulse(jeos_pulse), .eos_flag(eos_flag), .seq_wr(seq_wr),
  .flag_clr(flag_clr), .smp_time(smp_time), .res_sel(res_sel)
);

// File: tb/tb_adcseq_ctrl.sv
module tb_adcseq_ctrl;
  localparam int CH_W = 5, REG_MAX = 16, INJ_MAX = 4, SMP_W = 3, MAX_BURST = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [REG_MAX*CH_W-1:0] reg_seq = '0;
  logic [3:0] reg_len_m1 = '0;
  logic [INJ_MAX*CH_W-1:0] inj_seq = '0;
  logic [1:0] inj_len_m1 = '0;
  logic [(1<<CH_W)*SMP_W-1:0] smp_time = '0;
  logic [1:0] res_sel = '0;
  logic cont_en = 0, reg_disc_en = 0, inj_disc_en = 0, auto_inj_en = 0;
  logic [2:0] reg_burst_m1 = '0;
  logic [1:0] reg_edge_sel = '0, inj_edge_sel = '0;
  logic reg_trig = 0, inj_trig = 0, reg_sw_start = 0, inj_sw_start = 0, seq_wr = 0;
  logic [2:0] flag_clr = '0;
  logic reg_start_pend, inj_start_pend, conv_busy, conv_is_inj;
  logic [CH_W-1:0] conv_ch;
  logic eoc_pulse, eos_pulse, jeos_pulse, eoc_flag, eos_flag, jeos_flag;

  adcseq_ctrl dut (.*);

  always #4 clk = ~clk; // 125 MHz

  int checks = 0, fails = 0;
  bit finished = 0;
  int obs[$];
  int exp_q[$];
  int lst[$];

  // ---------------- behavioural reference model ----------------
  bit m_busy, m_inj, m_ra, m_ia, m_rpend, m_ipend, m_rprev, m_iprev;
  bit m_eoc, m_eos, m_jeos, m_feoc, m_feos, m_fjeos;
  int m_ch, m_cnt, m_rpos, m_ipos, m_bl;

  function automatic int bits_of(input logic [1:0] r);
    case (r)
      2'd0: return 12;
      2'd1: return 10;
      2'd2: return 8;
      default: return 6;
    endcase
  endfunction

  function automatic int window(input int ch);
    int code = int'((smp_time >> (ch * SMP_W)) & 3'h7);
    return code + 1 + bits_of(res_sel) + 3;
  endfunction

  function automatic bit fired(input logic [1:0] s, input bit p, input bit c);
    if (p == c) return 0;
    return c ? s[0] : s[1];
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    bit rhit, ihit, tr, ti, rr, ri, ev, es, ej, last;
    if (!rst_n) begin
      m_busy = 0; m_inj = 0; m_ra = 0; m_ia = 0; m_rpend = 0; m_ipend = 0;
      m_rprev = 0; m_iprev = 0; m_eoc = 0; m_eos = 0; m_jeos = 0;
      m_feoc = 0; m_feos = 0; m_fjeos = 0; m_ch = 0; m_cnt = 0;
      m_rpos = 0; m_ipos = 0; m_bl = 0;
    end else begin
      rhit = fired(reg_edge_sel, m_rprev, reg_trig);
      ihit = !auto_inj_en && fired(inj_edge_sel, m_iprev, inj_trig);
      m_rprev = reg_trig; m_iprev = inj_trig;
      tr = 0; ti = 0; rr = 0; ri = 0; ev = 0; es = 0; ej = 0;
      if (seq_wr) begin
        rr = m_ra; ri = m_ia;
        m_busy = 0; m_cnt = 0; m_rpos = 0; m_ipos = 0; m_ra = 0; m_ia = 0;
      end else if (m_busy) begin
        if (m_cnt == 0) begin
          m_busy = 0; ev = 1;
          if (m_inj) begin
            last = (m_ipos >= inj_len_m1);
            m_ipos = last ? 0 : m_ipos + 1;
            m_ia = !last && !inj_disc_en;
            ej = last;
          end else begin
            last = (m_rpos >= reg_len_m1);
            m_rpos = last ? 0 : m_rpos + 1;
            es = last;
            if (last) begin
              m_ra = cont_en && !reg_disc_en;
              if (auto_inj_en) m_ia = 1;
            end else begin
              m_ra = !reg_disc_en || (m_bl != 1);
              m_bl = m_bl - 1;
            end
          end
        end else m_cnt = m_cnt - 1;
      end else if (m_ia || m_ipend) begin
        if (!m_ia) begin ti = 1; m_ia = 1; end
        m_inj = 1; m_ch = int'(inj_seq[m_ipos*CH_W +: CH_W]);
        m_busy = 1; m_cnt = window(m_ch) - 1;
      end else if (m_ra || m_rpend) begin
        if (!m_ra) begin tr = 1; m_ra = 1; m_bl = int'(reg_burst_m1) + 1; end
        m_inj = 0; m_ch = int'(reg_seq[m_rpos*CH_W +: CH_W]);
        m_busy = 1; m_cnt = window(m_ch) - 1;
      end
      m_rpend = (m_rpend && !tr) || reg_sw_start || rhit || rr;
      m_ipend = (m_ipend && !ti) || inj_sw_start || ihit || ri;
      m_feoc  = (m_feoc && !flag_clr[0]) || ev;
      m_feos  = (m_feos && !flag_clr[1]) || es;
      m_fjeos = (m_fjeos && !flag_clr[2]) || ej;
      m_eoc = ev; m_eos = es; m_jeos = ej;
    end
  end

  // ---------------- per-cycle comparison and start log ----------------
  bit prev_busy = 0;
  always @(posedge clk) begin
    logic [15:0] got, want;
    #2;
    got  = {reg_start_pend, inj_start_pend, conv_busy, conv_ch, conv_is_inj,
            eoc_pulse, eos_pulse, jeos_pulse, eoc_flag, eos_flag, jeos_flag};
    want = {m_rpend, m_ipend, m_busy, m_ch[4:0], m_inj,
            m_eoc, m_eos, m_jeos, m_feoc, m_feos, m_fjeos};
    checks++;
    if (got !== want) begin
      fails++;
      $display("FAIL R9,R12 per-cycle model at %0t: got %h expected %h", $time, got, want);
    end
    if (conv_busy && !prev_busy) obs.push_back(int'(conv_ch) + (conv_is_inj ? 100 : 0));
    prev_busy = conv_busy;
  end

  // ---------------- helpers ----------------
  task automatic check(input string tag, input int got, input int want);
    checks++;
    if (got != want) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, want);
    end
  endtask

  task automatic chk_seq(input string tag);
    checks++;
    if (obs.size() != exp_q.size()) begin
      fails++;
      $display("FAIL %s: got %0d starts expected %0d", tag, obs.size(), exp_q.size());
      return;
    end
    foreach (exp_q[i]) if (obs[i] != exp_q[i]) begin
      fails++;
      $display("FAIL %s: start %0d got %0d expected %0d", tag, i, obs[i], exp_q[i]);
      return;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    reg_seq = '0; inj_seq = '0; reg_len_m1 = '0; inj_len_m1 = '0; res_sel = '0;
    cont_en = 0; reg_disc_en = 0; inj_disc_en = 0; auto_inj_en = 0; reg_burst_m1 = '0;
    reg_edge_sel = '0; inj_edge_sel = '0; reg_trig = 0; inj_trig = 0;
    reg_sw_start = 0; inj_sw_start = 0; seq_wr = 0; flag_clr = '0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    obs.delete();
  endtask

  task automatic load_reg();
    reg_seq = '0;
    foreach (lst[i]) reg_seq[i*CH_W +: CH_W] = CH_W'(lst[i]);
    reg_len_m1 = 4'(lst.size() - 1);
  endtask

  task automatic load_inj();
    inj_seq = '0;
    foreach (lst[i]) inj_seq[i*CH_W +: CH_W] = CH_W'(lst[i]);
    inj_len_m1 = 2'(lst.size() - 1);
  endtask

  task automatic sw_reg();
    @(negedge clk) reg_sw_start = 1;
    @(negedge clk) reg_sw_start = 0;
  endtask

  task automatic sw_inj();
    @(negedge clk) inj_sw_start = 1;
    @(negedge clk) inj_sw_start = 0;
  endtask

  task automatic pulse_inj_trig();
    @(negedge clk) inj_trig = 1;
    repeat (3) @(negedge clk);
    inj_trig = 0;
    repeat (60) @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end

  // ---------------- scenarios ----------------
  initial begin
    int n;
    for (int c = 0; c < (1 << CH_W); c++) smp_time[c*SMP_W +: SMP_W] = SMP_W'(c % 8);

    do_reset();
    @(posedge clk); #2;
    check("R12 reset flags", int'({eoc_flag, eos_flag, jeos_flag}), 0);
    check("R7 reset pend", int'({reg_start_pend, inj_start_pend, conv_busy}), 0);

    // Single pass, ordering, start bit, timing
    lst = '{5, 9, 2}; load_reg();
    sw_reg();
    @(posedge clk); #2;
    check("R7 pend cleared as busy rises", int'({conv_busy, reg_start_pend}), 2);
    n = 0;
    while (conv_busy) begin n++; @(posedge clk); #2; end
    check("R9 window res12 code5", n, 21);
    repeat (120) @(negedge clk);
    exp_q = '{5, 9, 2}; chk_seq("R1 regular order");
    check("R6 single stops", int'(conv_busy), 0);
    check("R12 flags after pass", int'({eoc_flag, eos_flag, jeos_flag}), 6);
    @(negedge clk) flag_clr = 3'b111;
    @(negedge clk) flag_clr = 3'b000;
    check("R12 flags cleared", int'({eoc_flag, eos_flag, jeos_flag}), 0);
    res_sel = 2'd3; lst = '{9}; load_reg();
    sw_reg();
    @(posedge clk); #2;
    n = 0;
    while (conv_busy) begin n++; @(posedge clk); #2; end
    check("R9 window res6 code1", n, 11);

    // Regular discontinuous bursts
    do_reset();
    lst = '{1, 2, 3, 4, 6}; load_reg();
    reg_disc_en = 1; reg_burst_m1 = 3'd1;
    repeat (3) begin sw_reg(); repeat (80) @(negedge clk); end
    exp_q = '{1, 2, 3, 4, 6}; chk_seq("R2 bursts of two, short tail");
    sw_reg(); repeat (80) @(negedge clk);
    exp_q = '{1, 2, 3, 4, 6, 1, 2}; chk_seq("R3 restart at entry 0");

    // Injected discontinuous with edge selection
    do_reset();
    lst = '{7, 8, 10}; load_inj(); inj_disc_en = 1;
    inj_edge_sel = 2'b01; pulse_inj_trig();
    inj_edge_sel = 2'b10; pulse_inj_trig();
    inj_edge_sel = 2'b11; pulse_inj_trig();
    inj_edge_sel = 2'b00; pulse_inj_trig();
    exp_q = '{107, 108, 110, 107}; chk_seq("R4 R8 one entry per edge, wrap");
    check("R8 edge select off", int'(inj_start_pend), 0);

    // Auto injection
    do_reset();
    lst = '{3, 4}; load_reg(); lst = '{11, 12}; load_inj();
    auto_inj_en = 1; inj_edge_sel = 2'b01;
    pulse_inj_trig();
    check("R5 external injected trigger ignored", obs.size() + int'(inj_start_pend), 0);
    sw_reg(); repeat (150) @(negedge clk);
    exp_q = '{3, 4, 111, 112}; chk_seq("R5 injected chained after regular");
    check("R12 both group flags", int'({eos_flag, jeos_flag}), 3);

    // Continuous
    do_reset();
    lst = '{1, 2}; load_reg(); cont_en = 1;
    sw_reg();
    for (int i = 0; i < 400 && obs.size() < 5; i++) @(negedge clk);
    while (obs.size() > 5) void'(obs.pop_back());
    exp_q = '{1, 2, 1, 2, 1}; chk_seq("R6 continuous passes");

    // Injected preemption
    do_reset();
    lst = '{1, 2, 3}; load_reg(); lst = '{20}; load_inj();
    sw_reg(); repeat (5) @(negedge clk);
    sw_inj(); repeat (150) @(negedge clk);
    exp_q = '{1, 120, 2, 3}; chk_seq("R11 injected between regular entries");

    // Abort on rewrite
    do_reset();
    lst = '{1, 2, 3}; load_reg();
    sw_reg();
    for (int i = 0; i < 200 && obs.size() < 2; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    seq_wr = 1;
    @(posedge clk); #2;
    check("R10 busy dropped after rewrite", int'(conv_busy), 0);
    @(negedge clk) seq_wr = 0;
    repeat (150) @(negedge clk);
    exp_q = '{1, 2, 1, 2, 3}; chk_seq("R10 pass restarts at entry 0");

    finished = 1;
    summary();
    $finish;
  end
endmodule